// File: doc/BRIEF.md
# Multi-Thread Bridge Flag Poller

This block sits in an FPGA next to an external USB bridge that exposes a synchronous slave-FIFO port split into four DMA threads. It walks a fixed visiting order of threads by driving a two-bit thread address. The address low bit and high bit each have a pin of their own. After every address change it holds off for a settle window so that the bridge's flags can catch up. Only then does it trust the shared current-thread flag, which means "room to accept" on a thread the FPGA writes into and "data waiting" on a thread the FPGA reads from.

On a read thread the shared flag must agree with that thread's own dedicated flag before a read burst opens. This keeps a stale shared flag from pulling reads out of an empty thread. During a burst the block pulses one word strobe per cycle toward a local source FIFO (writes) or a local sink FIFO (reads). It holds a strobe back while that FIFO cannot take part. A burst closes when the flag drops or a word cap is reached, and the poller then moves to the next thread. A read burst that stays open too long latches an error output.

Top module: `thread_flag_poller`

## Requirements
- R1: The thread address is presented as `thr_addr_msb` (bit 1) and `thr_addr_lsb` (bit 0). With default parameters it visits threads 0, 1, 3 in that order and wraps back to 0; thread 2 is never selected.
- R2: After reset and after every address change, no strobe is issued for the first 16 clock cycles (`SETTLE_CYC`). The earliest strobe appears on the 16th rising edge after the change.
- R3: Each flag input is read with its own polarity parameter. With the defaults all flags are active-low, so a raw 1 means "not ready".
- R4: On a write thread (bit clear in `THREAD_IS_READ`, default 4'b1000), a burst opens only if the current-thread flag shows room. Otherwise the poller advances one cycle after the settle window, with no strobe. `wr_strobe` is only ever asserted on write threads.
- R5: On a read thread, a burst opens only if both the current-thread flag and that thread's dedicated flag show data. Otherwise the thread is skipped with no `rd_strobe`.
- R6: A burst ends after `MAX_WORDS` strobes (default 8), and the poller moves to the next thread.
- R7: When the current-thread flag deasserts during a burst, strobes stop from the second rising edge after the raw change (two-flop synchronizer), and the poller moves on.
- R8: `wr_strobe` is never high while `src_empty` is high, and `rd_strobe` is never high while `snk_full` is high. Stalled cycles neither count as words nor end the burst.
- R9: If a read burst stays open for `TIMEOUT_CYC` cycles (default 64), `err_timeout` rises and stays high until reset.
- R10: While reset is high, the address is 0, both strobes are low and `err_timeout` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock (100 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| cur_flag_raw | input | 1 | Shared flag for the addressed thread, asynchronous |
| ded_flag_raw | input | 4 | Dedicated flag per thread, bit n for thread n, asynchronous |
| src_empty | input | 1 | Local source FIFO empty |
| snk_full | input | 1 | Local sink FIFO full |
| thr_addr_lsb | output | 1 | Thread address bit 0 |
| thr_addr_msb | output | 1 | Thread address bit 1 |
| wr_strobe | output | 1 | Pop one word from the source FIFO and write it to the bridge |
| rd_strobe | output | 1 | Read one word from the bridge and push it to the sink FIFO |
| err_timeout | output | 1 | Sticky read-burst timeout |

## Verification
A first strobe is due exactly on the 16th rising edge after an address change, a skipped thread hands over on the 17th, and a dropped flag silences strobes by the second edge. The bench therefore counts falling edges from the point where it sees the change and samples there, never on an edge. Word caps and skips are checked by tallying strobes per observed address between address changes. The timeout is sampled once well before and once well after its 64-cycle window.

// File: rtl/tfp_pkg.sv
package tfp_pkg;

    typedef enum logic [1:0] {
        PS_SETTLE = 2'd0,
        PS_BURST  = 2'd1,
        PS_NEXT   = 2'd2
    } poll_st_e;

    typedef struct packed {
        logic is_rd;
        logic start_ok;
        logic keep_ok;
        logic local_ok;
    } burst_view_t;

    function automatic logic flag_on(input logic raw, input logic act_low);
        return raw ^ act_low;
    endfunction

endpackage

// File: rtl/tfp_sync.sv
module tfp_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/tfp_slot_seq.sv
module tfp_slot_seq #(
    parameter int                     NUM_SLOTS = 3,
    parameter logic [2*NUM_SLOTS-1:0] SEQ       = '0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       advance,
    output logic [1:0] thread
);
    localparam int SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
    localparam logic [SW-1:0] LAST = SW'(NUM_SLOTS - 1);

    logic [SW-1:0] slot;

    always_ff @(posedge clk) begin
        if (rst)
            slot <= '0;
        else if (advance)
            slot <= (slot == LAST) ? '0 : slot + 1'b1;
    end

    assign thread = SEQ[2*int'(slot) +: 2];
endmodule

// File: rtl/tfp_timeout.sv
module tfp_timeout #(
    parameter int TIMEOUT_CYC = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic err
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            err <= 1'b0;
        end else begin
            if (!active)
                cnt <= '0;
            else if (cnt != TW'(TIMEOUT_CYC))
                cnt <= cnt + 1'b1;
            if (active && cnt == TW'(TIMEOUT_CYC - 1))
                err <= 1'b1;
        end
    end
endmodule

// File: rtl/thread_flag_poller.sv
module thread_flag_poller
    import tfp_pkg::*;
#(
    parameter int                     NUM_SLOTS      = 3,
    parameter logic [2*NUM_SLOTS-1:0] SEQ            = {2'd3, 2'd1, 2'd0},
    parameter logic [3:0]             THREAD_IS_READ = 4'b1000,
    parameter int                     SETTLE_CYC     = 16,
    parameter int                     MAX_WORDS      = 8,
    parameter int                     TIMEOUT_CYC    = 64,
    parameter logic                   CUR_ACT_LOW    = 1'b1,
    parameter logic [3:0]             DED_ACT_LOW    = 4'b1111
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cur_flag_raw,
    input  logic [3:0] ded_flag_raw,
    input  logic       src_empty,
    input  logic       snk_full,
    output logic       thr_addr_lsb,
    output logic       thr_addr_msb,
    output logic       wr_strobe,
    output logic       rd_strobe,
    output logic       err_timeout
);
    localparam int SCW = $clog2(SETTLE_CYC + 1);
    localparam int WCW = $clog2(MAX_WORDS + 1);

    logic [4:0]     flags_s;
    logic           cur_on;
    logic [3:0]     ded_on;
    logic [1:0]     thread;
    poll_st_e       st;
    logic [SCW-1:0] settle_cnt;
    logic [WCW-1:0] words;
    burst_view_t    bv;
    logic           strobe;

    tfp_sync #(
        .W      (5),
        .RST_VAL({DED_ACT_LOW, CUR_ACT_LOW})
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  ({ded_flag_raw, cur_flag_raw}),
        .q  (flags_s)
    );

    assign cur_on = flag_on(flags_s[0], CUR_ACT_LOW);

    for (genvar t = 0; t < 4; t++) begin : g_ded
        assign ded_on[t] = flag_on(flags_s[t+1], DED_ACT_LOW[t]);
    end

    tfp_slot_seq #(
        .NUM_SLOTS(NUM_SLOTS),
        .SEQ      (SEQ)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .advance(st == PS_NEXT),
        .thread (thread)
    );

    always_comb begin
        bv.is_rd    = THREAD_IS_READ[thread];
        bv.start_ok = bv.is_rd ? (cur_on && ded_on[thread]) : cur_on;
        bv.keep_ok  = cur_on && (words < WCW'(MAX_WORDS));
        bv.local_ok = bv.is_rd ? !snk_full : !src_empty;
    end

    assign strobe = (st == PS_BURST) && bv.keep_ok && bv.local_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= PS_SETTLE;
            settle_cnt <= '0;
            words      <= '0;
        end else begin
            case (st)
                PS_SETTLE: begin
                    if (settle_cnt == SCW'(SETTLE_CYC - 1)) begin
                        st    <= bv.start_ok ? PS_BURST : PS_NEXT;
                        words <= '0;
                    end else begin
                        settle_cnt <= settle_cnt + 1'b1;
                    end
                end
                PS_BURST: begin
                    if (!bv.keep_ok)
                        st <= PS_NEXT;
                    else if (strobe)
                        words <= words + 1'b1;
                end
                default: begin
                    st         <= PS_SETTLE;
                    settle_cnt <= '0;
                end
            endcase
        end
    end

    tfp_timeout #(
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_tmo (
        .clk   (clk),
        .rst   (rst),
        .active((st == PS_BURST) && bv.is_rd),
        .err   (err_timeout)
    );

    assign thr_addr_lsb = thread[0];
    assign thr_addr_msb = thread[1];
    assign wr_strobe    = strobe && !bv.is_rd;
    assign rd_strobe    = strobe && bv.is_rd;
endmodule

// File: rtl/tfp_chk.sv
module tfp_chk #(
    parameter logic [3:0] THREAD_IS_READ = 4'b1000
) (
    input logic clk,
    input logic rst,
    input logic thr_addr_lsb,
    input logic thr_addr_msb,
    input logic wr_strobe,
    input logic rd_strobe,
    input logic src_empty,
    input logic snk_full,
    input logic err_timeout
);
    logic [1:0] addr;
    assign addr = {thr_addr_msb, thr_addr_lsb};

    AST_WR_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> !src_empty); // R8
    AST_RD_NOT_FULL: assert property (@(posedge clk) disable iff (rst)
        rd_strobe |-> !snk_full); // R8
    AST_WR_ON_WRITE_THREAD: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> !THREAD_IS_READ[addr]); // R4
    AST_RD_ON_READ_THREAD: assert property (@(posedge clk) disable iff (rst)
        rd_strobe |-> THREAD_IS_READ[addr]); // R5
    AST_QUIET_AFTER_MOVE: assert property (@(posedge clk) disable iff (rst)
        (addr != $past(addr)) |-> !(wr_strobe || rd_strobe)); // R2
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_timeout |=> err_timeout); // R9
endmodule

bind thread_flag_poller tfp_chk #(
    .THREAD_IS_READ(THREAD_IS_READ)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .thr_addr_lsb(thr_addr_lsb),
    .thr_addr_msb(thr_addr_msb),
    .wr_strobe   (wr_strobe),
    .rd_strobe   (rd_strobe),
    .src_empty   (src_empty),
    .snk_full    (snk_full),
    .err_timeout (err_timeout)
);

// File: tb/thread_flag_poller_test.sv
module thread_flag_poller_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] cur_ok = 4'hF;
    logic [3:0] ded_ok = 4'hF;
    logic       src_empty = 1'b0;
    logic       snk_full  = 1'b0;
    logic       cur_flag_raw;
    logic [3:0] ded_flag_raw;
    logic       thr_addr_lsb, thr_addr_msb, wr_strobe, rd_strobe, err_timeout;
    logic [1:0] addr;

    int nchk  = 0;
    int nfail = 0;
    int wr_tot[4];
    int rd_tot[4];
    int seen2 = 0;
    bit wd_hit = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign addr         = {thr_addr_msb, thr_addr_lsb};
    assign cur_flag_raw = ~cur_ok[addr];   // active-low, follows the address (R3)
    assign ded_flag_raw = ~ded_ok;

    thread_flag_poller uut (
        .clk(clk), .rst(rst), .cur_flag_raw(cur_flag_raw), .ded_flag_raw(ded_flag_raw),
        .src_empty(src_empty), .snk_full(snk_full),
        .thr_addr_lsb(thr_addr_lsb), .thr_addr_msb(thr_addr_msb),
        .wr_strobe(wr_strobe), .rd_strobe(rd_strobe), .err_timeout(err_timeout)
    );

    initial begin
        for (int i = 0; i < 4; i++) begin wr_tot[i] = 0; rd_tot[i] = 0; end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_strobe) wr_tot[addr] = wr_tot[addr] + 1;
            if (rd_strobe) rd_tot[addr] = rd_tot[addr] + 1;
            if (addr == 2'd2) seen2 = seen2 + 1;
        end
    end

    task automatic check_eq(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_eq("R10 addr in reset", addr, 0);
        check_eq("R10 strobes in reset", wr_strobe + rd_strobe, 0);
        check_eq("R10 err in reset", err_timeout, 0);
        rst = 1'b0;
    endtask

    task automatic wait_addr(input int a, input string req);
        int n = 0;
        while (addr != a[1:0] && n < 400) begin
            @(negedge clk);
            n++;
        end
        check_eq(req, addr, a);
    endtask

    // R2: quiet for 15 falling edges after a change, strobe on the 16th
    task automatic settle_window(input string req);
        int early = 0;
        for (int i = 1; i <= 15; i++) begin
            @(negedge clk);
            early += wr_strobe + rd_strobe;
        end
        check_eq({req, " quiet"}, early, 0);
        @(negedge clk);
        check_eq({req, " first strobe"}, wr_strobe + rd_strobe, 1);
    endtask

    task automatic t_main_cycle();
        int w0, w1, r3, s2;
        cur_ok = 4'hF; ded_ok = 4'hF; src_empty = 0; snk_full = 0;
        w0 = wr_tot[0]; w1 = wr_tot[1]; r3 = rd_tot[3]; s2 = seen2;
        do_reset();
        settle_window("R2 after reset");
        wait_addr(1, "R1 second thread");
        check_eq("R1 lsb pin on thread 1", thr_addr_lsb, 1);
        check_eq("R6 write cap thread 0", wr_tot[0] - w0, 8);
        settle_window("R2 after move");
        wait_addr(3, "R1 third thread");
        check_eq("R1 msb pin on thread 3", thr_addr_msb, 1);
        check_eq("R6 write cap thread 1", wr_tot[1] - w1, 8);
        wait_addr(0, "R1 wrap");
        check_eq("R6 read cap thread 3", rd_tot[3] - r3, 8);
        check_eq("R1 thread 2 skipped", seen2 - s2, 0);
        check_eq("R9 no error on short burst", err_timeout, 0);
    endtask

    task automatic t_write_skip();
        int w0;
        cur_ok = 4'b1110; ded_ok = 4'hF; src_empty = 0; snk_full = 0;
        w0 = wr_tot[0];
        do_reset();
        repeat (16) @(negedge clk);
        check_eq("R4 still on thread 0 at edge 16", addr, 0);
        @(negedge clk);
        check_eq("R4 skip hands over at edge 17", addr, 1);
        check_eq("R3 raw-high flag means not ready", wr_tot[0] - w0, 0);
    endtask

    task automatic t_read_needs_both(input logic [3:0] c, input logic [3:0] d, input string req);
        int r3;
        cur_ok = c; ded_ok = d; src_empty = 0; snk_full = 0;
        do_reset();
        wait_addr(3, "R5 reach thread 3");
        r3 = rd_tot[3];
        wait_addr(0, "R5 leave thread 3");
        check_eq(req, rd_tot[3] - r3, 0);
    endtask

    task automatic t_flag_drop();
        int r3;
        cur_ok = 4'hF; ded_ok = 4'hF; src_empty = 0; snk_full = 0;
        do_reset();
        wait_addr(3, "R7 reach thread 3");
        r3 = rd_tot[3];
        repeat (16) @(negedge clk);
        @(negedge clk);
        cur_ok[3] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_eq("R7 strobe off two edges after drop", rd_strobe, 0);
        check_eq("R7 words before drop", rd_tot[3] - r3, 3);
        wait_addr(0, "R7 moves on after drop");
    endtask

    task automatic t_src_stall();
        int w0;
        cur_ok = 4'hF; ded_ok = 4'hF; src_empty = 1; snk_full = 0;
        w0 = wr_tot[0];
        do_reset();
        repeat (40) @(negedge clk);
        check_eq("R8 no write while empty", wr_tot[0] - w0, 0);
        check_eq("R8 burst held on thread 0", addr, 0);
        src_empty = 0;
        wait_addr(1, "R8 resumes");
        check_eq("R8 stalls not counted", wr_tot[0] - w0, 8);
    endtask

    task automatic t_timeout();
        int r3;
        cur_ok = 4'hF; ded_ok = 4'hF; src_empty = 0; snk_full = 1;
        do_reset();
        wait_addr(3, "R9 reach thread 3");
        r3 = rd_tot[3];
        repeat (56) @(negedge clk);
        check_eq("R9 no error before window", err_timeout, 0);
        check_eq("R8 no read while full", rd_tot[3] - r3, 0);
        repeat (60) @(negedge clk);
        check_eq("R9 error after window", err_timeout, 1);
        snk_full = 0;
        wait_addr(0, "R9 burst drains");
        check_eq("R9 read count after drain", rd_tot[3] - r3, 8);
        check_eq("R9 error sticky", err_timeout, 1);
    endtask

    task automatic run_all();
        t_main_cycle();
        t_write_skip();
        t_read_needs_both(4'hF, 4'b0111, "R5 dedicated flag off blocks read");
        t_read_needs_both(4'b0111, 4'hF, "R5 shared flag off blocks read");
        t_flag_drop();
        t_src_stall();
        t_timeout();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                wd_hit = 1;
            end
        join_any
        disable fork;
        if (wd_hit) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        end
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule